// File: doc/BRIEF.md
# Block transfer byte packer

This engine sits between a byte-wide card data path and a 16-bit word buffer. In the receive direction it takes bytes from the card and packs them into buffer words. In the transmit direction it takes words from the buffer head and sends their bytes to the card. Software programs a block length and a block count through two 11-bit fields, each encoded as the value minus one. A start strobe then launches a transfer in the chosen direction.

While a transfer is active the engine moves at most one byte per clock. It counts bytes within the current block and blocks within the transfer. When the final byte of the final block has moved, it drops its active flag and raises a one-cycle done pulse. Two conditions stall the flow until they clear. In receive, no new word is begun while the buffer fill count is above the almost-full level. In transmit, no byte is offered while the buffer is empty. Both counters can be read back at any time and show the bytes and blocks still to go.

Top module: `bxp_engine`

## Requirements
- R1: After reset the engine is inactive, both remaining counters read 1, xfer_done is low, and no buffer strobe or card handshake output is asserted.
- R2: A cycle with cfg_len_we high loads cfg_wdata + 1 (range 1 to 2048) as the block length and also sets the remaining-byte counter to that value.
- R3: A cycle with cfg_cnt_we high loads cfg_wdata + 1 as the block count and sets the remaining-block counter to it. The same write reloads the remaining-byte counter from the stored block length.
- R4: In receive (xfer_dir_rx = 1), the first byte of each word lands in bits 7:0 and the next byte of the same block lands in bits 15:8. The word is pushed together with its second byte. If the block ends after the low byte, the word is pushed at once with bits 15:8 equal to zero.
- R5: In transmit (xfer_dir_rx = 0), bits 7:0 of the buffer head go out first and then bits 15:8. The word is popped with its second byte, or with its low byte alone when that byte ends the block.
- R6: Each transferred byte lowers the remaining-byte counter by one. When the counter would reach zero it reloads the block length and the remaining-block counter drops by one. len_left and cnt_left always show these live values.
- R7: The byte that ends the last block clears xfer_active and reloads both counters to their programmed values at the next edge. xfer_done is high for exactly that one cycle.
- R8: In receive, card_rx_ready stays low at the start of a word while buffer fill exceeds the almost-full level, and the transfer resumes by itself once the fill is no longer above that level.
- R9: In transmit, card_tx_valid stays low while buffer fill is zero, and the transfer resumes by itself when a word arrives.
- R10: While inactive, card input activity has no effect: no push, no pop, no handshake output, and both counters hold.
- R11: With the card side always ready and no stall, a transfer of L bytes per block and N blocks keeps xfer_active high for exactly L*N cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_len_we | input | 1 | Write strobe for block length |
| cfg_cnt_we | input | 1 | Write strobe for block count |
| cfg_wdata | input | FIELD_W | Length or count value minus one |
| xfer_start | input | 1 | Start a transfer |
| xfer_dir_rx | input | 1 | Direction at start: 1 receive from card, 0 transmit to card |
| card_rx_valid | input | 1 | Card offers a received byte |
| card_rx_data | input | 8 | Received byte |
| card_rx_ready | output | 1 | Engine accepts the received byte |
| card_tx_valid | output | 1 | Engine offers a byte to send |
| card_tx_data | output | 8 | Byte to send |
| card_tx_ready | input | 1 | Card accepts the byte |
| buf_push | output | 1 | Push a packed word into the buffer |
| buf_push_data | output | 16 | Packed word |
| buf_pop | output | 1 | Remove the buffer head word |
| buf_head | input | 16 | Current buffer head word |
| buf_fill | input | FILL_W | Words held in the buffer |
| buf_af_level | input | FILL_W | Almost-full level for receive flow control |
| len_left | output | FIELD_W+1 | Remaining bytes in the current block |
| cnt_left | output | FIELD_W+1 | Remaining blocks in the transfer |
| xfer_active | output | 1 | Transfer in progress |
| xfer_done | output | 1 | One-cycle pulse when a transfer ends |

## Verification
Packing, unpacking and the push and pop strobes are combinational on the cycle a byte is taken, so they land in the buffer model at that same edge. The counters, xfer_active and xfer_done change one edge later. Config writes show on len_left and cnt_left one edge after the strobe. The bench drives and samples on the falling edge. It reads each result only after the rising edge at which it is due. It waits out a stall for many cycles before it checks that nothing has moved.

// File: rtl/bxp_pkg.sv
package bxp_pkg;

    typedef enum logic {
        DIR_TX = 1'b0,
        DIR_RX = 1'b1
    } xfer_dir_e;

    typedef enum logic {
        LANE_LO = 1'b0,
        LANE_HI = 1'b1
    } lane_e;

    typedef struct packed {
        logic [7:0] hi;
        logic [7:0] lo;
    } word_t;

endpackage

// File: rtl/bxp_counters.sv
module bxp_counters #(
    parameter int FIELD_W = 11
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               len_we,
    input  logic               cnt_we,
    input  logic [FIELD_W-1:0] wdata,
    input  logic               step,
    output logic [FIELD_W:0]   byte_left,
    output logic [FIELD_W:0]   blk_left,
    output logic               last_byte,
    output logic               final_byte
);
    localparam int CW = FIELD_W + 1;
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] byte_len_q, blk_len_q, byte_cnt_q, blk_cnt_q;
    logic [CW-1:0] decoded;

    assign decoded = {1'b0, wdata} + ONE;

    always_ff @(posedge clk) begin
        if (rst) begin
            byte_len_q <= ONE;
            blk_len_q  <= ONE;
            byte_cnt_q <= ONE;
            blk_cnt_q  <= ONE;
        end else if (len_we) begin
            byte_len_q <= decoded;
            byte_cnt_q <= decoded;
        end else if (cnt_we) begin
            blk_len_q  <= decoded;
            blk_cnt_q  <= decoded;
            byte_cnt_q <= byte_len_q;
        end else if (step) begin
            if (byte_cnt_q == ONE) begin
                byte_cnt_q <= byte_len_q;
                if (blk_cnt_q == ONE) begin
                    blk_cnt_q <= blk_len_q;
                end else begin
                    blk_cnt_q <= blk_cnt_q - ONE;
                end
            end else begin
                byte_cnt_q <= byte_cnt_q - ONE;
            end
        end
    end

    assign byte_left  = byte_cnt_q;
    assign blk_left   = blk_cnt_q;
    assign last_byte  = (byte_cnt_q == ONE);
    assign final_byte = last_byte && (blk_cnt_q == ONE);
endmodule

// File: rtl/bxp_rx_pack.sv
module bxp_rx_pack
    import bxp_pkg::*;
#(
    parameter int FILL_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              enable,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic              last_byte,
    input  logic [FILL_W-1:0] fill,
    input  logic [FILL_W-1:0] af_level,
    output logic              ready,
    output logic              take,
    output logic              push,
    output word_t             push_word
);
    lane_e      lane_q;
    logic [7:0] low_q;
    logic       paused;

    assign paused = (fill > af_level);
    assign ready  = enable && ((lane_q == LANE_HI) || !paused);
    assign take   = ready && byte_valid;
    assign push   = take && ((lane_q == LANE_HI) || last_byte);

    always_comb begin
        if (lane_q == LANE_HI) begin
            push_word.lo = low_q;
            push_word.hi = byte_data;
        end else begin
            push_word.lo = byte_data;
            push_word.hi = 8'h00;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            lane_q <= LANE_LO;
            low_q  <= 8'h00;
        end else if (take) begin
            if ((lane_q == LANE_LO) && !last_byte) begin
                lane_q <= LANE_HI;
                low_q  <= byte_data;
            end else begin
                lane_q <= LANE_LO;
            end
        end
    end
endmodule

// File: rtl/bxp_tx_unpack.sv
module bxp_tx_unpack
    import bxp_pkg::*;
#(
    parameter int FILL_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              enable,
    input  word_t             head,
    input  logic [FILL_W-1:0] fill,
    input  logic              card_ready,
    input  logic              last_byte,
    output logic              valid,
    output logic [7:0]        data,
    output logic              take,
    output logic              pop
);
    lane_e lane_q;

    assign valid = enable && (fill != '0);
    assign data  = (lane_q == LANE_HI) ? head.hi : head.lo;
    assign take  = valid && card_ready;
    assign pop   = take && ((lane_q == LANE_HI) || last_byte);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            lane_q <= LANE_LO;
        end else if (take) begin
            if ((lane_q == LANE_LO) && !last_byte) begin
                lane_q <= LANE_HI;
            end else begin
                lane_q <= LANE_LO;
            end
        end
    end
endmodule

// File: rtl/bxp_engine.sv
module bxp_engine
    import bxp_pkg::*;
#(
    parameter int FIELD_W = 11,
    parameter int FILL_W  = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_len_we,
    input  logic               cfg_cnt_we,
    input  logic [FIELD_W-1:0] cfg_wdata,
    input  logic               xfer_start,
    input  logic               xfer_dir_rx,
    input  logic               card_rx_valid,
    input  logic [7:0]         card_rx_data,
    output logic               card_rx_ready,
    output logic               card_tx_valid,
    output logic [7:0]         card_tx_data,
    input  logic               card_tx_ready,
    output logic               buf_push,
    output logic [15:0]        buf_push_data,
    output logic               buf_pop,
    input  logic [15:0]        buf_head,
    input  logic [FILL_W-1:0]  buf_fill,
    input  logic [FILL_W-1:0]  buf_af_level,
    output logic [FIELD_W:0]   len_left,
    output logic [FIELD_W:0]   cnt_left,
    output logic               xfer_active,
    output logic               xfer_done
);
    logic      active_q, done_q;
    xfer_dir_e dir_q;
    logic      rx_en, tx_en, rx_take, tx_take, step;
    logic      last_byte, final_byte;
    word_t     rx_word;

    assign rx_en = active_q && (dir_q == DIR_RX);
    assign tx_en = active_q && (dir_q == DIR_TX);
    assign step  = rx_take || tx_take;

    bxp_counters #(.FIELD_W(FIELD_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .len_we     (cfg_len_we),
        .cnt_we     (cfg_cnt_we),
        .wdata      (cfg_wdata),
        .step       (step),
        .byte_left  (len_left),
        .blk_left   (cnt_left),
        .last_byte  (last_byte),
        .final_byte (final_byte)
    );

    bxp_rx_pack #(.FILL_W(FILL_W)) u_rx (
        .clk        (clk),
        .rst        (rst),
        .clear      (xfer_start),
        .enable     (rx_en),
        .byte_valid (card_rx_valid),
        .byte_data  (card_rx_data),
        .last_byte  (last_byte),
        .fill       (buf_fill),
        .af_level   (buf_af_level),
        .ready      (card_rx_ready),
        .take       (rx_take),
        .push       (buf_push),
        .push_word  (rx_word)
    );

    assign buf_push_data = rx_word;

    bxp_tx_unpack #(.FILL_W(FILL_W)) u_tx (
        .clk        (clk),
        .rst        (rst),
        .clear      (xfer_start),
        .enable     (tx_en),
        .head       (word_t'(buf_head)),
        .fill       (buf_fill),
        .card_ready (card_tx_ready),
        .last_byte  (last_byte),
        .valid      (card_tx_valid),
        .data       (card_tx_data),
        .take       (tx_take),
        .pop        (buf_pop)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            dir_q    <= DIR_TX;
            done_q   <= 1'b0;
        end else begin
            done_q <= step && final_byte;
            if (xfer_start) begin
                active_q <= 1'b1;
                dir_q    <= xfer_dir_rx ? DIR_RX : DIR_TX;
            end else if (step && final_byte) begin
                active_q <= 1'b0;
            end
        end
    end

    assign xfer_active = active_q;
    assign xfer_done   = done_q;
endmodule

// File: rtl/bxp_engine_chk.sv
module bxp_engine_chk #(
    parameter int FIELD_W = 11,
    parameter int FILL_W  = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              card_rx_valid,
    input logic              card_rx_ready,
    input logic              card_tx_valid,
    input logic              card_tx_ready,
    input logic              buf_push,
    input logic              buf_pop,
    input logic [FILL_W-1:0] buf_fill,
    input logic [FIELD_W:0]  len_left,
    input logic [FIELD_W:0]  cnt_left,
    input logic              xfer_active,
    input logic              xfer_done
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !xfer_active |-> (!buf_push && !buf_pop && !card_rx_ready && !card_tx_valid)); // R10
    AST_TX_NEEDS_WORD: assert property (@(posedge clk) disable iff (rst)
        card_tx_valid |-> (buf_fill != '0)); // R9
    AST_DONE_ENDS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        xfer_done |-> !xfer_active); // R7
    AST_DONE_AFTER_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        $rose(xfer_done) |-> $fell(xfer_active)); // R7
    AST_PUSH_WITH_BYTE: assert property (@(posedge clk) disable iff (rst)
        buf_push |-> (card_rx_valid && card_rx_ready)); // R4
    AST_POP_WITH_BYTE: assert property (@(posedge clk) disable iff (rst)
        buf_pop |-> (card_tx_valid && card_tx_ready)); // R5
    AST_COUNTS_NONZERO: assert property (@(posedge clk) disable iff (rst)
        (len_left != '0) && (cnt_left != '0)); // R6
endmodule

bind bxp_engine bxp_engine_chk #(.FIELD_W(FIELD_W), .FILL_W(FILL_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .card_rx_valid (card_rx_valid),
    .card_rx_ready (card_rx_ready),
    .card_tx_valid (card_tx_valid),
    .card_tx_ready (card_tx_ready),
    .buf_push      (buf_push),
    .buf_pop       (buf_pop),
    .buf_fill      (buf_fill),
    .len_left      (len_left),
    .cnt_left      (cnt_left),
    .xfer_active   (xfer_active),
    .xfer_done     (xfer_done)
);

// File: tb/sim_bxp_engine.sv
module sim_bxp_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_len_we = 1'b0, cfg_cnt_we = 1'b0;
    logic [10:0] cfg_wdata = '0;
    logic        xfer_start = 1'b0, xfer_dir_rx = 1'b0;
    logic        card_rx_valid = 1'b0;
    logic [7:0]  card_rx_data;
    logic        card_rx_ready, card_tx_valid;
    logic [7:0]  card_tx_data;
    logic        card_tx_ready = 1'b0;
    logic        buf_push, buf_pop;
    logic [15:0] buf_push_data, buf_head;
    logic [6:0]  buf_fill;
    logic [6:0]  buf_af_level = 7'd63;
    logic [11:0] len_left, cnt_left;
    logic        xfer_active, xfer_done;

    logic        clr = 1'b0, load = 1'b0;
    logic [15:0] load_data = '0;
    logic [15:0] mem [64];
    logic [7:0]  txlog [64];
    logic [6:0]  wr, rd;
    logic [7:0]  rx_seq;
    int          ntx, done_cnt, act_cyc, cyc;
    int          checks = 0, errors = 0;

    always #10 clk = ~clk;

    bxp_engine u0 (.*);

    assign buf_fill     = wr - rd;
    assign buf_head     = mem[rd[5:0]];
    assign card_rx_data = rx_seq;

    always_ff @(posedge clk) begin
        if (clr) begin
            wr <= '0; rd <= '0; rx_seq <= '0;
            ntx <= 0; done_cnt <= 0; act_cyc <= 0;
        end else begin
            if (buf_push) mem[wr[5:0]] <= buf_push_data;
            if (load)     mem[wr[5:0]] <= load_data;
            if (buf_push || load) wr <= wr + 7'd1;
            if (buf_pop) rd <= rd + 7'd1;
            if (card_rx_valid && card_rx_ready) rx_seq <= rx_seq + 8'd1;
            if (card_tx_valid && card_tx_ready) begin
                txlog[ntx[5:0]] <= card_tx_data;
                ntx <= ntx + 1;
            end
            if (xfer_done) done_cnt <= done_cnt + 1;
            if (xfer_active) act_cyc <= act_cyc + 1;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
            $finish;
        end
    end
    initial cyc = 0;

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check_eq(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_env();
        clr = 1'b1; tick(); clr = 1'b0;
    endtask

    task automatic prog(int len_enc, int cnt_enc);
        cfg_wdata = 11'(len_enc); cfg_len_we = 1'b1; tick(); cfg_len_we = 1'b0;
        cfg_wdata = 11'(cnt_enc); cfg_cnt_we = 1'b1; tick(); cfg_cnt_we = 1'b0;
    endtask

    task automatic start(logic dir_rx);
        xfer_dir_rx = dir_rx; xfer_start = 1'b1; tick(); xfer_start = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 600 && done_cnt == 0; i++) tick();
        tick();
    endtask

    task automatic load_word(logic [15:0] w);
        load_data = w; load = 1'b1; tick(); load = 1'b0;
    endtask

    task automatic run_rx(int len_enc, int cnt_enc);
        int L = len_enc + 1, N = cnt_enc + 1, wpb = (len_enc + 2) / 2;
        int b = 0, wi = 0;
        clear_env();
        prog(len_enc, cnt_enc);
        buf_af_level = 7'd63;
        card_rx_valid = 1'b1;
        start(1'b1);
        wait_done();
        card_rx_valid = 1'b0;
        check_eq("R7", "rx done pulses", done_cnt, 1);
        check_eq("R7", "rx active after", int'(xfer_active), 0);
        check_eq("R7", "rx len reload", int'(len_left), L);
        check_eq("R7", "rx cnt reload", int'(cnt_left), N);
        check_eq("R11", "rx active cycles", act_cyc, L * N);
        check_eq("R4", "rx words pushed", int'(wr), N * wpb);
        for (int k = 0; k < N; k++) begin
            for (int j = 0; j < wpb; j++) begin
                int lo = b & 255;
                int hi = (2 * j + 1 < L) ? ((b + 1) & 255) : 0;
                check_eq("R4", "rx word", int'(mem[wi]), hi * 256 + lo);
                b += (2 * j + 1 < L) ? 2 : 1;
                wi++;
            end
        end
    endtask

    task automatic run_tx(int len_enc, int cnt_enc);
        int L = len_enc + 1, N = cnt_enc + 1, wpb = (len_enc + 2) / 2;
        int nb = 0, wi = 0;
        clear_env();
        prog(len_enc, cnt_enc);
        for (int w = 0; w < N * wpb; w++)
            load_word({8'(8'h80 + w), 8'(w * 3 + 1)});
        card_tx_ready = 1'b1;
        start(1'b0);
        wait_done();
        card_tx_ready = 1'b0;
        check_eq("R7", "tx done pulses", done_cnt, 1);
        check_eq("R7", "tx len reload", int'(len_left), L);
        check_eq("R11", "tx active cycles", act_cyc, L * N);
        check_eq("R5", "tx bytes sent", ntx, L * N);
        check_eq("R5", "tx words popped", int'(rd), N * wpb);
        for (int k = 0; k < N; k++) begin
            for (int j = 0; j < wpb; j++) begin
                check_eq("R5", "tx low byte", int'(txlog[nb]), (wi * 3 + 1) & 255);
                nb++;
                if (2 * j + 1 < L) begin
                    check_eq("R5", "tx high byte", int'(txlog[nb]), (128 + wi) & 255);
                    nb++;
                end
                wi++;
            end
        end
    endtask

    initial begin
        clr = 1'b1;
        repeat (3) tick();
        rst = 1'b0; clr = 1'b0;
        tick();
        // R1 reset state
        check_eq("R1", "active", int'(xfer_active), 0);
        check_eq("R1", "len_left", int'(len_left), 1);
        check_eq("R1", "cnt_left", int'(cnt_left), 1);
        check_eq("R1", "done", int'(xfer_done), 0);
        check_eq("R1", "strobes", int'({buf_push, buf_pop, card_rx_ready, card_tx_valid}), 0);

        // R2 largest length field
        cfg_wdata = 11'h7FF; cfg_len_we = 1'b1; tick(); cfg_len_we = 1'b0;
        check_eq("R2", "len max", int'(len_left), 2048);
        cfg_wdata = 11'd4; cfg_len_we = 1'b1; tick(); cfg_len_we = 1'b0;
        check_eq("R2", "len 5", int'(len_left), 5);

        // R10 idle ignores card side
        clear_env();
        prog(2, 1);
        card_rx_valid = 1'b1; card_tx_ready = 1'b1;
        repeat (10) tick();
        check_eq("R10", "idle no push", int'(wr), 0);
        check_eq("R10", "idle len hold", int'(len_left), 3);
        check_eq("R10", "idle cnt hold", int'(cnt_left), 2);
        check_eq("R10", "idle rx ready", int'(card_rx_ready), 0);
        card_rx_valid = 1'b0; card_tx_ready = 1'b0;

        // R4 R5 R6 R7 R11 sweeps
        for (int le = 0; le < 5; le++)
            for (int ce = 0; ce < 3; ce++) begin
                run_rx(le, ce);
                run_tx(le, ce);
            end

        // R8 receive pause above almost-full level
        clear_env();
        prog(7, 0);
        buf_af_level = 7'd1;
        card_rx_valid = 1'b1;
        start(1'b1);
        repeat (20) tick();
        check_eq("R8", "paused fill", int'(buf_fill), 2);
        check_eq("R8", "paused ready", int'(card_rx_ready), 0);
        check_eq("R6", "live len", int'(len_left), 4);
        check_eq("R8", "still active", int'(xfer_active), 1);
        buf_af_level = 7'd63;
        wait_done();
        check_eq("R8", "resumed words", int'(wr), 4);
        check_eq("R8", "resumed done", done_cnt, 1);
        card_rx_valid = 1'b0;

        // R9 transmit pause on empty buffer
        clear_env();
        prog(3, 0);
        load_word(16'hB2A1);
        card_tx_ready = 1'b1;
        start(1'b0);
        repeat (20) tick();
        check_eq("R9", "bytes before stall", ntx, 2);
        check_eq("R9", "tx valid empty", int'(card_tx_valid), 0);
        check_eq("R6", "live len tx", int'(len_left), 2);
        load_word(16'hD4C3);
        wait_done();
        check_eq("R9", "bytes after resume", ntx, 4);
        check_eq("R9", "byte 3", int'(txlog[2]), 8'hC3);
        check_eq("R9", "byte 4", int'(txlog[3]), 8'hD4);
        card_tx_ready = 1'b0;

        // R3 count write reloads byte counter mid-block
        clear_env();
        prog(7, 0);
        buf_af_level = 7'd1;
        card_rx_valid = 1'b1;
        start(1'b1);
        repeat (20) tick();
        check_eq("R6", "partial len", int'(len_left), 4);
        cfg_wdata = 11'd2; cfg_cnt_we = 1'b1; tick(); cfg_cnt_we = 1'b0;
        check_eq("R3", "cnt loaded", int'(cnt_left), 3);
        check_eq("R3", "len reloaded", int'(len_left), 8);
        card_rx_valid = 1'b0;
        rst = 1'b1; tick(); rst = 1'b0; tick();
        check_eq("R1", "reset ends xfer", int'(xfer_active), 0);
        check_eq("R1", "reset len", int'(len_left), 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule